// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches a processor bus and reports a transfer that is left hanging. When a bus cycle begins, the monitor starts timing it. If no transfer acknowledge arrives within a programmed period, it raises a one-clock error pulse and goes back to idle. Other logic turns that pulse into a bus-error termination.

The period is an 8-bit value counted in units of eight system clocks, so it spans 8 to 2040 clocks. The period and an enable bit are held in a configuration register. After each reset only the first write to that register takes effect. After reset the monitor is off and the period holds its maximum value. A period of zero is invalid and disarms the monitor.

Top module: `bus_timeout_mon`

## Requirements
- R1: After reset `timeout_err` is low and the monitor is disabled (enable = 0, period = 8'hFF). A bus cycle started before any configuration write never produces an error.
- R2: Only the first `cfg_wr` after reset loads `cfg_period` and `cfg_enable`. Every later write is ignored until the next reset.
- R3: Let E0 be the clock edge that samples `cyc_start` high while the monitor is idle and enabled with a period P other than zero. With no acknowledge, `timeout_err` goes high in the clock that follows edge E0+8*P.
- R4: `timeout_err` is high for exactly one clock. The monitor is then idle: an acknowledge that arrives later has no effect, and no further error follows unless a new cycle starts.
- R5: An acknowledge sampled at any edge from E0+1 to E0+8*P-1 ends the watch, and no error is signalled.
- R6: An acknowledge sampled at edge E0+8*P, the edge where the timeout would fire, takes priority, and no error is signalled.
- R7: With the enable bit 0, the counters stay at zero and `timeout_err` never rises.
- R8: With a programmed period of 0, the monitor never arms and `timeout_err` never rises.
- R9: `cyc_start` while a cycle is already being watched is ignored. The timeout still falls at edge E0+8*P of the first start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Configuration write strobe (honoured once per reset) |
| cfg_period | input | 8 | Timeout period in units of eight clocks |
| cfg_enable | input | 1 | Monitor enable |
| cyc_start | input | 1 | A bus cycle begins this clock |
| xfer_ack | input | 1 | Transfer acknowledge |
| timeout_err | output | 1 | One-clock pulse when a cycle is left unacknowledged |

## Verification
The error output is registered. An unacknowledged cycle therefore shows `timeout_err` in the clock that follows edge E0+8*P, and no earlier or later clock. The bench drives inputs on the falling edge and counts rising edges from E0. It samples on every falling edge up to a few clocks past the expected edge. Each sample is compared with a value computed from P and from the edge at which the acknowledge was presented. This sweep covers periods 1 to 8 and 255, acknowledges one edge early and on the very edge of the timeout, a late acknowledge, a restart in mid-cycle, and the disabled and zero-period settings. Configuration takes effect at the edge after the write, so every sweep starts at least one clock after it.

// File: rtl/bto_pkg.sv
package bto_pkg;
  parameter int PERIOD_W = 8;
  parameter int PRESCALE = 8;
  typedef enum logic {ST_IDLE = 1'b0, ST_WATCH = 1'b1} bto_state_e;
endpackage

// File: rtl/bto_cfg_reg.sv
module bto_cfg_reg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [PW-1:0] period_in,
  input  logic          en_in,
  output logic [PW-1:0] period_q,
  output logic          en_q
);
  logic locked_q, locked_d;
  logic [PW-1:0] period_d;
  logic en_d;
  logic load;

  assign load = wr && !locked_q;

  always_comb begin
    period_d = period_q;
    en_d     = en_q;
    locked_d = locked_q;
    if (load) begin
      period_d = period_in;
      en_d     = en_in;
      locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= {PW{1'b1}};
      en_q     <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      period_q <= period_d;
      en_q     <= en_d;
      locked_q <= locked_d;
    end
  end

  // R2: once loaded, the configuration never changes again
  a_r2_write_once: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> ($stable(period_q) && $stable(en_q)));
endmodule

// File: rtl/bto_prescaler.sv
module bto_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (run)  cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: a cleared prescaler is at zero on the following clock
  a_r7_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/bto_period_cnt.sv
module bto_period_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = count;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon
  import bto_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic                cfg_enable,
  input  logic                cyc_start,
  input  logic                xfer_ack,
  output logic                timeout_err
);
  logic [PERIOD_W-1:0] period_q;
  logic                en_q;
  logic                valid;
  logic                watching;
  logic                tick;
  logic                hit;
  logic                clr;
  logic [PERIOD_W-1:0] cnt;
  logic                err_d;
  bto_state_e          state_q, state_d;

  bto_cfg_reg #(.PW(PERIOD_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .period_in(cfg_period),
    .en_in(cfg_enable), .period_q(period_q), .en_q(en_q)
  );

  assign valid    = en_q && (period_q != '0);
  assign watching = (state_q == ST_WATCH);
  assign hit      = watching && tick && (cnt == period_q - 1'b1);
  assign clr      = !watching || !valid || xfer_ack || hit;

  bto_prescaler #(.DIV(PRESCALE)) i_pre (
    .clk(clk), .rst_n(rst_n), .run(watching), .clr(clr), .tick(tick)
  );

  bto_period_cnt #(.W(PERIOD_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(tick), .count(cnt)
  );

  always_comb begin
    state_d = state_q;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE:  if (valid && cyc_start && !xfer_ack) state_d = ST_WATCH;
      ST_WATCH: begin
        if (!valid || xfer_ack) begin
          state_d = ST_IDLE;
        end else if (hit) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      timeout_err <= 1'b0;
    end else begin
      state_q     <= state_d;
      timeout_err <= err_d;
    end
  end

  // R4: the error is a single-clock pulse
  a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> !timeout_err);
  // R4: after the error the monitor is idle
  a_r4_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !watching);
  // R5/R6: an acknowledge is never followed by an error
  a_r6_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !timeout_err);
  // R7: disabled monitor raises no error
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !timeout_err);
  // R8: zero period raises no error and never arms
  a_r8_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == '0) |=> (!timeout_err && !watching));
  // R3: the period count never passes the programmed period while watching
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    watching |-> (cnt < period_q));
endmodule

// File: tb/test_bus_timeout_mon.sv
module test_bus_timeout_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_period = '0;
  logic       cfg_enable = 1'b0;
  logic       cyc_start = 1'b0;
  logic       xfer_ack = 1'b0;
  logic       timeout_err;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bus_timeout_mon i_bus_timeout_mon (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_period(cfg_period),
    .cfg_enable(cfg_enable), .cyc_start(cyc_start), .xfer_ack(xfer_ack),
    .timeout_err(timeout_err)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: timeout_err=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_wr = 0; cyc_start = 0; xfer_ack = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] p, input logic e);
    cfg_period = p; cfg_enable = e; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  // exp_k: edge index (from E0) whose next clock carries the error, 0 = never
  task automatic watch(input string req, input int len, input int exp_k,
                       input int ack_k, input int restart_k);
    cyc_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cyc_start = 1'b0;
    for (int k = 1; k <= len; k++) begin
      xfer_ack  = (k == ack_k);
      cyc_start = (k == restart_k);
      @(posedge clk);
      @(negedge clk);
      check(req, timeout_err, (k == exp_k));
    end
    xfer_ack = 1'b0; cyc_start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 reset", timeout_err, 1'b0);
    // R1: unconfigured monitor is disabled
    watch("R1 unconfigured", 40, 0, 0, 0);

    for (int p = 1; p <= 9; p++) begin
      int P;
      P = (p == 9) ? 255 : p;
      do_reset();
      cfg_write(8'(P), 1'b1);
      // R3 / R4: plain timeout, late ack after it has no effect
      watch("R3 timeout", 8*P + 4, 8*P, 8*P + 2, 0);
      // R5: ack one edge early
      watch("R5 early ack", 8*P + 4, 0, 8*P - 1, 0);
      // R6: ack on the timeout edge
      watch("R6 ack same edge", 8*P + 4, 0, 8*P, 0);
      // R9: restart during watch ignored
      watch("R9 restart ignored", 8*P + 4, 8*P, 0, 4);
    end

    // R2: second write ignored (period stays 2, enable stays 1)
    do_reset();
    cfg_write(8'd2, 1'b1);
    cfg_write(8'd5, 1'b0);
    watch("R2 write once", 24, 16, 0, 0);

    // R7: disabled
    do_reset();
    cfg_write(8'd3, 1'b0);
    watch("R7 disabled", 40, 0, 0, 0);
    cfg_write(8'd3, 1'b1);
    watch("R7 disabled after late enable", 40, 0, 0, 0);

    // R8: zero period
    do_reset();
    cfg_write(8'd0, 1'b1);
    watch("R8 zero period", 40, 0, 0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule